// File: doc/BRIEF.md
# Latched Barrel Shift and Rotate Unit

This block is a memory-mapped 32-bit shifter on a byte-wide register bus. Software stages a word in four byte registers, commits it into a hidden working register by touching the most significant staging byte, and then starts a one-cycle logical shift or rotate by writing an amount register. When the operation finishes, the result is written back into the staging bytes, where it can be read.

Each amount register is eight bits wide. Its low nibble is a two's-complement count. A positive count moves bits towards the most significant end, and a negative count moves them towards the least significant end by the count's magnitude. The upper nibble does nothing except hold the value that was written and return it on a read. The working register is always treated as unsigned, so a shift fills the vacated bits with zeros and never copies the sign bit.

Top module: `shift_rotate_unit`

## Requirements
- R1: After reset, every register reads 0: staging bytes at addresses 0-3, shift amount at 4, rotate amount at 5. The working register is also 0, so an operation with count 0 returns 0.
- R2: Staging byte k (address k, k = 0..3) holds bits 8k+7..8k of the word, which is little-endian order. A written byte reads back unchanged.
- R3: A write to address 3 loads the working register with the written byte as bits 31..24 and staging bytes 2..0 as the lower bits.
- R4: A read of address 3 also loads the working register from all four staging bytes.
- R5: A write to address 0, 1 or 2 leaves the working register unchanged until a commit happens.
- R6: Writing address 4 with a low nibble n from 1 to 7 shifts the working register left by n bits and fills with zeros.
- R7: Writing address 4 with a low nibble from 8 to 15 (−8 to −1) shifts right by the magnitude and fills with zeros, even when bit 31 is 1.
- R8: Writing address 5 rotates the working register through all 32 bits. The direction and count follow the same signed low-nibble code.
- R9: The upper nibble of address 4 and address 5 is stored and reads back. It has no effect on the count.
- R10: A read of address 4 or 5 starts no operation.
- R11: A count of 0 leaves the value unchanged.
- R12: After an operation, staging bytes 0-3 hold the result. A cycle that both writes and reads address 3 commits the newly written top byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
Two functions can fall in the same cycle. A read of the top staging byte starts a commit of the staged word, and a write to that byte starts a commit with a new top byte. The bench raises both strobes at address 3 in one cycle and writes a top byte that differs from the staged one. It then runs a zero-count shift to bring the working register out to the staging bytes. The case passes only if the written byte appears as bits 31..24 and the three staged lower bytes are intact.

// File: rtl/sru_pkg.sv
package sru_pkg;

   typedef enum logic {
      OP_SHIFT  = 1'b0,
      OP_ROTATE = 1'b1
   } sru_op_e;

   // Magnitude of a two's-complement count; the most negative code maps to its full magnitude.
   function automatic logic [7:0] cnt_mag(input logic [7:0] cnt, input int unsigned w);
      logic [7:0] m;
      logic       neg;
      neg = cnt[w-1];
      m   = neg ? (~cnt + 8'd1) : cnt;
      for (int i = 0; i < 8; i++) begin
         if (i >= int'(w)) m[i] = 1'b0;
      end
      return m;
   endfunction

endpackage

// File: rtl/sru_stage.sv
module sru_stage #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   output logic [DATA_W-1:0] stage_q,
   output logic [DATA_W-1:0] stage_next
);
   localparam int NBYTES = DATA_W / BYTE_W;

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      logic hit;
      assign hit = wr_en && (addr == ADDR_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     stage_q[b*BYTE_W +: BYTE_W] <= '0;
         else if (load)  stage_q[b*BYTE_W +: BYTE_W] <= load_val[b*BYTE_W +: BYTE_W];
         else if (hit)   stage_q[b*BYTE_W +: BYTE_W] <= wdata;
      end

      assign stage_next[b*BYTE_W +: BYTE_W] = hit ? wdata : stage_q[b*BYTE_W +: BYTE_W];
   end

endmodule

// File: rtl/sru_barrel.sv
module sru_barrel #(
   parameter int DATA_W     = 32,
   parameter int AMT_W      = 4,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [AMT_W-1:0]  cnt,
   input  sru_pkg::sru_op_e  op,
   output logic [DATA_W-1:0] dout
);
   import sru_pkg::*;

   localparam int SH_W = $clog2(DATA_W) + 1;

   logic             go_right;
   logic             do_rot;
   logic [AMT_W-1:0] mag;

   assign go_right = cnt[AMT_W-1];
   assign do_rot   = (op == OP_ROTATE);
   assign mag      = AMT_W'(cnt_mag(8'(cnt), AMT_W));

   if (LOG_STAGES) begin : g_log
      logic [DATA_W-1:0] lvl [AMT_W+1];
      assign lvl[0] = din;
      for (genvar s = 0; s < AMT_W; s++) begin : g_lvl
         localparam int K = 1 << s;
         logic [DATA_W-1:0] moved;
         always_comb begin
            if (go_right)
               moved = do_rot ? ((lvl[s] >> K) | (lvl[s] << (DATA_W - K))) : (lvl[s] >> K);
            else
               moved = do_rot ? ((lvl[s] << K) | (lvl[s] >> (DATA_W - K))) : (lvl[s] << K);
         end
         assign lvl[s+1] = mag[s] ? moved : lvl[s];
      end
      assign dout = lvl[AMT_W];
   end else begin : g_direct
      logic [SH_W-1:0] n;
      logic [SH_W-1:0] back;
      assign n    = SH_W'(mag);
      assign back = SH_W'(DATA_W) - n;
      always_comb begin
         if (go_right)
            dout = (din >> n) | (do_rot && n != '0 ? (din << back) : '0);
         else
            dout = (din << n) | (do_rot && n != '0 ? (din >> back) : '0);
      end
   end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit #(
   parameter int DATA_W     = 32,
   parameter int BYTE_W     = 8,
   parameter int ADDR_W     = 3,
   parameter int AMT_W      = 4,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata
);
   import sru_pkg::*;

   localparam int NBYTES    = DATA_W / BYTE_W;
   localparam int IDX_TOP   = NBYTES - 1;
   localparam int IDX_SHIFT = NBYTES;
   localparam int IDX_ROT   = NBYTES + 1;

   if (DATA_W % BYTE_W != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of BYTE_W");
   end
   if (IDX_ROT >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (AMT_W > BYTE_W || (1 << (AMT_W - 1)) >= DATA_W) begin : g_bad_amt
      $error("AMT_W out of range");
   end

   logic [DATA_W-1:0] core_q;
   logic [DATA_W-1:0] stage_q;
   logic [DATA_W-1:0] stage_next;
   logic [DATA_W-1:0] result;
   logic [BYTE_W-1:0] shamt_q;
   logic [BYTE_W-1:0] rotamt_q;
   logic              hit_shift;
   logic              hit_rot;
   logic              op_fire;
   logic              commit;
   sru_op_e           op_sel;

   assign hit_shift = wr_en && (addr == ADDR_W'(IDX_SHIFT));
   assign hit_rot   = wr_en && (addr == ADDR_W'(IDX_ROT));
   assign op_fire   = hit_shift || hit_rot;
   assign op_sel    = hit_rot ? OP_ROTATE : OP_SHIFT;
   assign commit    = (wr_en || rd_en) && (addr == ADDR_W'(IDX_TOP));

   sru_stage #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W),
      .ADDR_W (ADDR_W)
   ) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .addr       (addr),
      .wdata      (wdata),
      .load       (op_fire),
      .load_val   (result),
      .stage_q    (stage_q),
      .stage_next (stage_next)
   );

   sru_barrel #(
      .DATA_W     (DATA_W),
      .AMT_W      (AMT_W),
      .LOG_STAGES (LOG_STAGES)
   ) u_barrel (
      .din  (core_q),
      .cnt  (wdata[AMT_W-1:0]),
      .op   (op_sel),
      .dout (result)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       core_q <= '0;
      else if (op_fire) core_q <= result;
      else if (commit)  core_q <= stage_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shamt_q  <= '0;
         rotamt_q <= '0;
      end else begin
         if (hit_shift) shamt_q  <= wdata;
         if (hit_rot)   rotamt_q <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (addr == ADDR_W'(i)) rdata = stage_q[i*BYTE_W +: BYTE_W];
      end
      if (addr == ADDR_W'(IDX_SHIFT)) rdata = shamt_q;
      if (addr == ADDR_W'(IDX_ROT))   rdata = rotamt_q;
   end

endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 3,
   parameter int AMT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              rd_en,
   input logic              wr_en,
   input logic [BYTE_W-1:0] wdata,
   input logic [DATA_W-1:0] core_q,
   input logic [DATA_W-1:0] stage_q
);
   localparam int NBYTES = DATA_W / BYTE_W;
   localparam logic [ADDR_W-1:0] A_TOP = ADDR_W'(NBYTES - 1);
   localparam logic [ADDR_W-1:0] A_SH  = ADDR_W'(NBYTES);
   localparam logic [ADDR_W-1:0] A_RO  = ADDR_W'(NBYTES + 1);

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (core_q == '0 && stage_q == '0));

   p_write_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_TOP) |=>
         core_q == {$past(wdata), $past(stage_q[DATA_W-BYTE_W-1:0])});

   p_read_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && addr == A_TOP) |=> core_q == $past(stage_q));

   p_low_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en && addr < A_TOP) |=> $stable(core_q));

   p_shift_left_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SH && wdata[AMT_W-1:0] == AMT_W'(1)) |=>
         core_q == {$past(core_q[DATA_W-2:0]), 1'b0});

   p_amt_read_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && (addr == A_SH || addr == A_RO)) |=> $stable(core_q));

   p_zero_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr == A_SH || addr == A_RO) && wdata[AMT_W-1:0] == '0) |=>
         core_q == $past(core_q));

   p_copy_back_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr == A_SH || addr == A_RO)) |=> stage_q == core_q);

endmodule

bind shift_rotate_unit sru_checker #(
   .DATA_W (DATA_W),
   .BYTE_W (BYTE_W),
   .ADDR_W (ADDR_W),
   .AMT_W  (AMT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .rd_en   (rd_en),
   .wr_en   (wr_en),
   .wdata   (wdata),
   .core_q  (core_q),
   .stage_q (stage_q)
);

// File: tb/tb_shift_rotate_unit.sv
`timescale 1ns/1ps
module tb_shift_rotate_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   shift_rotate_unit dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
      .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
   );

   function automatic logic [31:0] model(input logic [31:0] v, input logic [3:0] c, input bit rot);
      int n;
      n = c[3] ? 16 - int'(c) : int'(c);
      for (int i = 0; i < n; i++) begin
         if (c[3]) v = {rot ? v[0] : 1'b0, v[31:1]};
         else      v = {v[30:0], rot ? v[31] : 1'b0};
      end
      return v;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic load32(input logic [31:0] v);
      for (int i = 0; i < 4; i++) wr(3'(i), v[i*8 +: 8]);
   endtask

   task automatic read32(output logic [31:0] v);
      logic [7:0] b;
      for (int i = 0; i < 4; i++) begin
         rd(3'(i), b);
         v[i*8 +: 8] = b;
      end
   endtask

   task automatic run_op(input logic [2:0] a, input logic [7:0] c, output logic [31:0] v);
      wr(a, c);
      read32(v);
   endtask

   task automatic t_reset;
      logic [7:0] b;
      logic [31:0] v;
      for (int i = 0; i < 6; i++) begin
         rd(3'(i), b);
         check("R1 register clear", 32'(b), 32'h0);
      end
      run_op(3'd4, 8'h00, v);
      check("R1 working register clear", v, 32'h0);
   endtask

   task automatic t_bytes;
      logic [31:0] v;
      load32(32'h44332211);
      read32(v);
      check("R2 little-endian bytes", v, 32'h44332211);
   endtask

   task automatic t_commit_shift_left;
      logic [31:0] v;
      load32(32'h80000001);
      run_op(3'd4, 8'h00, v);
      check("R3 R11 commit and zero count", v, 32'h80000001);
      run_op(3'd4, 8'h01, v);
      check("R6 left by 1", v, model(32'h80000001, 4'h1, 1'b0));
      load32(32'h00F0000F);
      run_op(3'd4, 8'h07, v);
      check("R6 left by 7", v, model(32'h00F0000F, 4'h7, 1'b0));
   endtask

   task automatic t_shift_right;
      logic [31:0] v;
      load32(32'h80000000);
      run_op(3'd4, 8'h0C, v);
      check("R7 right by 4 no sign fill", v, 32'h08000000);
      run_op(3'd4, 8'h08, v);
      check("R7 right by 8", v, 32'h00080000);
      load32(32'hFFFFFFFF);
      run_op(3'd4, 8'h0F, v);
      check("R7 right by 1 zero fill", v, 32'h7FFFFFFF);
   endtask

   task automatic t_rotate;
      logic [31:0] v;
      load32(32'h80000001);
      run_op(3'd5, 8'h01, v);
      check("R8 rotate left 1", v, 32'h00000003);
      run_op(3'd5, 8'h0F, v);
      check("R8 rotate right 1", v, 32'h80000001);
      run_op(3'd5, 8'h08, v);
      check("R8 rotate right 8", v, model(32'h80000001, 4'h8, 1'b1));
      run_op(3'd5, 8'h00, v);
      check("R11 rotate zero", v, 32'h01800000);
   endtask

   task automatic t_upper_nibble;
      logic [31:0] v;
      logic [7:0] b;
      load32(32'h00000001);
      run_op(3'd4, 8'hA1, v);
      check("R9 upper nibble ignored shift", v, 32'h00000002);
      rd(3'd4, b);
      check("R9 shift reg readback", 32'(b), 32'hA1);
      run_op(3'd5, 8'h5E, v);
      check("R9 upper nibble ignored rotate", v, 32'h80000000);
      rd(3'd5, b);
      check("R9 rotate reg readback", 32'(b), 32'h5E);
   endtask

   task automatic t_read_no_op;
      logic [31:0] v;
      logic [7:0] b;
      load32(32'h0000F00D);
      wr(3'd4, 8'h00);
      rd(3'd4, b);
      rd(3'd5, b);
      rd(3'd4, b);
      read32(v);
      check("R10 amount reads start nothing", v, 32'h0000F00D);
   endtask

   task automatic t_low_no_commit;
      logic [31:0] v;
      load32(32'h12345678);
      wr(3'd0, 8'hAA);
      run_op(3'd4, 8'h00, v);
      check("R5 low byte write uncommitted", v, 32'h12345678);
   endtask

   task automatic t_read_commit;
      logic [31:0] v;
      logic [7:0] b;
      load32(32'h12345678);
      wr(3'd1, 8'hBB);
      rd(3'd3, b);
      run_op(3'd4, 8'h00, v);
      check("R4 read of top byte commits", v, 32'h1234BB78);
   endtask

   task automatic t_concurrent;
      logic [31:0] v;
      load32(32'h01020304);
      @(negedge clk);
      addr = 3'd3; wdata = 8'h99; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      run_op(3'd4, 8'h00, v);
      check("R12 simultaneous read and write of top byte", v, 32'h99020304);
      run_op(3'd5, 8'h04, v);
      check("R12 result copied back", v, model(32'h99020304, 4'h4, 1'b1));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_bytes();
      t_commit_shift_left();
      t_shift_right();
      t_rotate();
      t_upper_nibble();
      t_read_no_op();
      t_low_no_commit();
      t_read_commit();
      t_concurrent();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule